// File: doc/BRIEF.md
# Rotating Rank Refresh Scheduler

This block paces refresh for a memory channel with up to eight ranks. It counts packet-slot ticks from the link into super frames. A super frame lasts 42 slots or 40 slots, depending on the gear-ratio select. After a programmable number of super frames it raises one refresh request. The request names a target rank, and the rank advances by one each time a request is acknowledged. Over a whole rotation, each rank is therefore served once every (interval × super-frame length × rank count) slots.

A request stays up until the command issuer acknowledges it. If further intervals expire before that acknowledgement, a small saturating pending count holds them. Each one is then offered in turn, so refreshes are not silently skipped. Writing an interval of zero stops refresh altogether. It clears the slot count, the frame count, the pending count and the rank pointer, so a test can restart refresh at a known moment.

Top module: `rank_refresh_sched`

## Requirements
- R1: After reset, `req_valid` is 0 and `req_rank` is 0.
- R2: A super frame is 40 slot ticks when `gear_sel` is 2'b10, and 42 slot ticks for 2'b00, 2'b01 and 2'b11.
- R3: With `interval_cfg` = N (nonzero), one interval expiry occurs every N super frames. `req_valid` rises in the cycle after the final slot tick of the interval.
- R4: While `req_valid` is 1 and `req_ack` is 0, `req_valid` and `req_rank` hold their values.
- R5: `req_ack` with `req_valid` = 1 retires one request and advances `req_rank` by one, wrapping from RANKS-1 to 0. `req_ack` with `req_valid` = 0 has no effect.
- R6: Expiries that arrive while requests are outstanding are counted up to PEND_MAX (4). Expiries beyond that are dropped. Each acknowledgement retires one counted request.
- R7: When an expiry and an accepted acknowledgement fall in the same cycle, the outstanding count is unchanged and `req_rank` still advances.
- R8: When `interval_cfg` is 0, all counters, the outstanding count and the rank pointer are cleared on the next edge. A later nonzero value starts a full interval from slot 0 at rank 0.
- R9: The super-frame length is sampled on the first slot tick of each frame. A change of `gear_sel` during a frame takes effect at the next frame. While disabled, the next frame uses the select as it stands.
- R10: Counting advances only on cycles with `slot_tick` = 1. Idle cycles never raise a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One link packet slot has elapsed |
| gear_sel | input | 2 | Gear ratio; 2'b10 selects 40-slot super frames |
| interval_cfg | input | 4 | Refresh spacing in super frames; 0 disables |
| req_ack | input | 1 | Issuer has taken the current request |
| req_valid | output | 1 | A refresh request is outstanding |
| req_rank | output | 3 | Rank targeted by the outstanding request |

## Verification
All state sits in one register stage. The closing slot tick of an interval therefore shows up as `req_valid` right after that tick's edge. An acknowledgement, a disable and an ignored acknowledgement likewise show their effect one edge after they are applied. The bench drives every input on the falling edge. It holds each input for whole cycles and reads the outputs on the next falling edge, exactly one rising edge after the stimulus. Boundary checks sample both one tick before and exactly at the expected expiry, so an off-by-one in the frame length or in the interval count is seen from either side.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int CFG_W    = 4;
    localparam int SLOT_W   = 6;
    localparam int LEN_STD  = 42;
    localparam int LEN_ALT  = 40;

    typedef enum logic [1:0] {
        GEAR_EQUAL = 2'b00,
        GEAR_FAST  = 2'b01,
        GEAR_SLOW  = 2'b10,
        GEAR_SPARE = 2'b11
    } gear_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] len;
    } frame_st_t;

    typedef struct packed {
        logic [CFG_W-1:0] frames;
    } ivl_st_t;

    function automatic logic [SLOT_W-1:0] frame_len(gear_e g);
        return (g == GEAR_SLOW) ? SLOT_W'(LEN_ALT) : SLOT_W'(LEN_STD);
    endfunction

endpackage

// File: rtl/rrs_frame_timer.sv
module rrs_frame_timer
    import rrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       slot_tick,
    input  logic [1:0] gear_sel,
    output logic       frame_end
);

    frame_st_t         st_d, st_q;
    logic [SLOT_W-1:0] eff_len;

    always_comb begin
        st_d    = st_q;
        // The length is taken from the select at the first slot of a frame.
        eff_len = (st_q.slot == '0) ? frame_len(gear_e'(gear_sel)) : st_q.len;
        frame_end = enable && slot_tick && (st_q.slot == eff_len - SLOT_W'(1));
        if (!enable) begin
            st_d.slot = '0;
        end else if (slot_tick) begin
            if (st_q.slot == '0) begin
                st_d.len = eff_len;
            end
            st_d.slot = frame_end ? '0 : st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.len  <= SLOT_W'(LEN_STD);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rrs_interval_timer.sv
module rrs_interval_timer
    import rrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] interval_cfg,
    input  logic             frame_end,
    output logic             expire
);

    ivl_st_t          st_d, st_q;
    logic [CFG_W:0]   next_cnt;

    always_comb begin
        st_d     = st_q;
        next_cnt = {1'b0, st_q.frames} + (CFG_W+1)'(1);
        // ">=" keeps the interval bounded if the setting shrinks mid-count.
        expire   = frame_end && (next_cnt >= {1'b0, interval_cfg});
        if (interval_cfg == '0) begin
            st_d.frames = '0;
        end else if (frame_end) begin
            st_d.frames = expire ? '0 : next_cnt[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rrs_request_queue.sv
module rrs_request_queue #(
    parameter  int RANKS    = 8,
    parameter  int PEND_MAX = 4,
    localparam int RANK_W   = $clog2(RANKS),
    localparam int PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              expire,
    input  logic              ack,
    output logic              valid,
    output logic [RANK_W-1:0] rank
);

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic [RANK_W-1:0] rank;
    } queue_st_t;

    queue_st_t st_d, st_q;
    logic      take;

    always_comb begin
        st_d  = st_q;
        valid = (st_q.pend != '0);
        rank  = st_q.rank;
        take  = ack && valid;
        if (!enable) begin
            st_d = '0;
        end else begin
            if (take) begin
                st_d.rank = (st_q.rank == RANK_W'(RANKS - 1)) ? '0
                                                             : st_q.rank + RANK_W'(1);
            end
            unique case ({expire, take})
                2'b10: if (st_q.pend != PEND_W'(PEND_MAX))
                           st_d.pend = st_q.pend + PEND_W'(1);
                2'b01: st_d.pend = st_q.pend - PEND_W'(1);
                default: st_d.pend = st_q.pend;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rank_refresh_sched.sv
module rank_refresh_sched
    import rrs_pkg::*;
#(
    parameter  int RANKS    = 8,
    parameter  int PEND_MAX = 4,
    localparam int RANK_W   = $clog2(RANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic [1:0]        gear_sel,
    input  logic [CFG_W-1:0]  interval_cfg,
    input  logic              req_ack,
    output logic              req_valid,
    output logic [RANK_W-1:0] req_rank
);

    logic enable;
    logic frame_end;
    logic expire;

    assign enable = (interval_cfg != '0);

    rrs_frame_timer u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .slot_tick (slot_tick),
        .gear_sel  (gear_sel),
        .frame_end (frame_end)
    );

    rrs_interval_timer u_ivl (
        .clk          (clk),
        .rst_n        (rst_n),
        .interval_cfg (interval_cfg),
        .frame_end    (frame_end),
        .expire       (expire)
    );

    rrs_request_queue #(
        .RANKS    (RANKS),
        .PEND_MAX (PEND_MAX)
    ) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .expire (expire),
        .ack    (req_ack),
        .valid  (req_valid),
        .rank   (req_rank)
    );

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter  int RANKS  = 8,
    localparam int RANK_W = $clog2(RANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_tick,
    input logic [3:0]        interval_cfg,
    input logic              req_ack,
    input logic              req_valid,
    input logic [RANK_W-1:0] req_rank
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack && interval_cfg != '0) |=> req_valid); // R4

    AST_RANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack && interval_cfg != '0) |=> $stable(req_rank)); // R4

    AST_RANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack && interval_cfg != '0) |=>
        (req_rank == (($past(req_rank) == RANK_W'(RANKS - 1)) ? '0
                                                             : $past(req_rank) + RANK_W'(1)))); // R5

    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && req_ack) |=> $stable(req_rank)); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_cfg == '0) |=> (!req_valid && req_rank == '0)); // R8

    AST_NO_TICK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_tick && !req_valid) |=> !req_valid); // R10

endmodule

bind rank_refresh_sched rrs_checker #(.RANKS(RANKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_tick    (slot_tick),
    .interval_cfg (interval_cfg),
    .req_ack      (req_ack),
    .req_valid    (req_valid),
    .req_rank     (req_rank)
);

// File: tb/rank_refresh_sched_test.sv
module rank_refresh_sched_test;

    localparam int CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_tick = 1'b0;
    logic [1:0] gear_sel = 2'b00;
    logic [3:0] interval_cfg = 4'd0;
    logic       req_ack = 1'b0;
    logic       req_valid;
    logic [2:0] req_rank;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CYC/2) clk = ~clk;

    rank_refresh_sched uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_tick    (slot_tick),
        .gear_sel     (gear_sel),
        .interval_cfg (interval_cfg),
        .req_ack      (req_ack),
        .req_valid    (req_valid),
        .req_rank     (req_rank)
    );

    // {gear[1:0], interval[3:0], ticks[10:0], expected req_valid}
    localparam int NV = 10;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 4'd1,  11'd41,  1'b0},   // R3 one short of 42
        {2'd0, 4'd1,  11'd42,  1'b1},   // R3
        {2'd2, 4'd1,  11'd39,  1'b0},   // R2 40-slot frames
        {2'd2, 4'd1,  11'd40,  1'b1},   // R2
        {2'd1, 4'd2,  11'd83,  1'b0},   // R3 two frames
        {2'd1, 4'd2,  11'd84,  1'b1},   // R3
        {2'd3, 4'd1,  11'd41,  1'b0},   // R2 spare code = 42
        {2'd3, 4'd1,  11'd42,  1'b1},   // R2
        {2'd2, 4'd15, 11'd599, 1'b0},   // R3 largest interval
        {2'd2, 4'd15, 11'd600, 1'b1}    // R3
    };

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            slot_tick = 1'b1;
            @(negedge clk);
        end
        slot_tick = 1'b0;
    endtask

    task automatic ack1();
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic restart(logic [1:0] g, logic [3:0] t);
        interval_cfg = 4'd0;
        gear_sel     = g;
        @(negedge clk);
        interval_cfg = t;
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid", int'(req_valid), 0);
        check("R1 rank", int'(req_rank), 0);

        for (int i = 0; i < NV; i++) begin
            restart(VEC[i][17:16], VEC[i][15:12]);
            ticks(int'(VEC[i][11:1]));
            check("R2/R3 valid", int'(req_valid), int'(VEC[i][0]));
            if (VEC[i][0]) check("R3 rank", int'(req_rank), 0);
        end

        // R10: idle cycles do not advance counting
        restart(2'd2, 4'd1);
        repeat (100) @(negedge clk);
        check("R10 idle", int'(req_valid), 0);
        ticks(40);
        check("R10 after ticks", int'(req_valid), 1);

        // R4: request held without ack
        repeat (5) @(negedge clk);
        check("R4 valid held", int'(req_valid), 1);
        check("R4 rank held", int'(req_rank), 0);

        // R5: rank rotation with wrap
        for (int i = 0; i < 8; i++) begin
            ack1();
            check("R5 rank step", int'(req_rank), (i + 1) % 8);
            check("R5 retired", int'(req_valid), 0);
            ticks(40);
            check("R5 next req", int'(req_valid), 1);
        end
        ack1();
        ack1();
        check("R5 idle ack rank", int'(req_rank), 1);
        check("R5 idle ack valid", int'(req_valid), 0);

        // R6: several expiries counted
        restart(2'd2, 4'd1);
        ticks(120);
        ack1();
        check("R6 second", int'(req_valid), 1);
        check("R6 rank1", int'(req_rank), 1);
        ack1();
        check("R6 third", int'(req_valid), 1);
        ack1();
        check("R6 drained", int'(req_valid), 0);
        check("R6 rank3", int'(req_rank), 3);

        // R6: saturation at four
        restart(2'd2, 4'd1);
        ticks(240);
        ack1(); ack1(); ack1();
        check("R6 sat remaining", int'(req_valid), 1);
        ack1();
        check("R6 sat drained", int'(req_valid), 0);
        check("R6 sat rank", int'(req_rank), 4);

        // R7: expiry and ack in the same cycle
        restart(2'd2, 4'd1);
        ticks(40);
        ticks(39);
        slot_tick = 1'b1;
        req_ack   = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        req_ack   = 1'b0;
        check("R7 still valid", int'(req_valid), 1);
        check("R7 rank", int'(req_rank), 1);
        ack1();
        check("R7 drained", int'(req_valid), 0);

        // R8: disable clears and restarts a full interval
        restart(2'd2, 4'd1);
        ticks(40);
        ack1();
        ticks(40);
        ticks(20);
        interval_cfg = 4'd0;
        @(negedge clk);
        check("R8 cleared valid", int'(req_valid), 0);
        check("R8 cleared rank", int'(req_rank), 0);
        interval_cfg = 4'd1;
        ticks(39);
        check("R8 full interval", int'(req_valid), 0);
        ticks(1);
        check("R8 restart req", int'(req_valid), 1);
        check("R8 restart rank", int'(req_rank), 0);

        // R9: gear change mid frame waits for the next frame
        restart(2'd0, 4'd1);
        ticks(10);
        gear_sel = 2'd2;
        ticks(31);
        check("R9 old length", int'(req_valid), 0);
        ticks(1);
        check("R9 old length end", int'(req_valid), 1);
        ack1();
        ticks(39);
        check("R9 new length", int'(req_valid), 0);
        ticks(1);
        check("R9 new length end", int'(req_valid), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule